// File: doc/BRIEF.md
# Partitioned-Table Parallel Distributed-Arithmetic FIR Filter

This block is a 64-tap FIR filter with fixed coefficients and no multipliers. It takes one signed 12-bit sample per clock when `in_valid` is high. It returns one full-precision filtered sample per clock, a fixed number of cycles later. The taps are split into groups of four. For every bit position of the stored samples, each group reads a 16-entry table of precomputed coefficient sums. The table address is made of that bit taken from each of the group's four taps.

For each bit position, a registered adder tree adds the table outputs of all groups into a plane sum. A second registered tree adds the plane sums after each one is shifted by its bit weight. The sum from the sign bit is subtracted. All twelve bit positions are handled in the same cycle, so the filter never stalls.

Coefficients are fixed when the design is built. They are generated from two parameters, so no table has to be written out. The filter is used as a streaming stage: a new sample may arrive on any cycle, and idle cycles between samples are allowed.

Top module: `da_fir`

## Requirements
- R1: For every accepted sample n, the output equals the sum over k = 0..63 of c[k]·x[n−k]. Here x[n−k] is the k-th most recently accepted sample, and samples older than the last reset count as zero.
- R2: Coefficient c[i] = ((173·i + 5) mod 4096) − 2048, a 12-bit signed value. Tap 0 multiplies the newest sample. A single sample of 1 followed by zeros therefore returns c[0], c[1], … c[63] in order.
- R3: `out_valid` rises for exactly one cycle for each accepted sample. It is high in the 10th clock edge counted from the edge that captures the sample, where the capturing edge is edge 1.
- R4: Samples accepted on consecutive cycles produce results on consecutive cycles, with no gaps and no reordering.
- R5: A cycle with `in_valid` low does not shift the delay line and produces no result. Once the pipeline has drained, `out_data` holds the last result.
- R6: A synchronous reset (`rst` high) clears the delay line and every pipeline stage. During reset and afterwards, `out_valid` stays low and `out_data` reads 0 until the first result of a new sample is due.
- R7: `out_data` is 31 bits wide, two's complement, and never overflows, including for full-scale inputs such as a constant −2048.
- R8: Inputs are two's complement. The most negative input, −2048 (bit 11 set, all other bits clear), is weighted −2048, not +2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_data` holds a sample this cycle |
| in_data | input | 12 | Input sample, two's complement |
| out_valid | output | 1 | `out_data` holds a new result this cycle |
| out_data | output | 31 | Filtered result, full precision, two's complement |

## Verification
Each result is due in the 10th clock edge counted from the edge that captured its sample. When the driver hands a sample to the design, it stamps the expected value with that due cycle and pushes both into the scoreboard queue. The monitor samples on the falling clock edge. It compares the value and also requires that the current cycle equals the stamped cycle. A result that arrives early, arrives late or was never expected is reported as a failure. After an idle stretch longer than the pipeline, the bench reads `out_data` again to confirm it still holds the last result.

// File: rtl/da_fir.sv
`timescale 1ns/1ps
module da_fir #(
  parameter int NTAPS = 64,
  parameter int DW    = 12,
  parameter int CW    = 12,
  parameter int GS    = 4,
  parameter int CSTEP = 173,
  parameter int COFF  = 5,
  localparam int OW   = DW + CW + $clog2(NTAPS) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int NG  = NTAPS / GS;
  localparam int GL  = $clog2(NG);
  localparam int PL  = $clog2(DW);
  localparam int NP  = 2 ** PL;
  localparam int SW  = CW + $clog2(NTAPS) + 1;
  localparam int LAT = 2 + GL + PL;

  function automatic logic signed [CW-1:0] coef(input int i);
    int v;
    v = ((i * CSTEP + COFF) % (2 ** CW)) - 2 ** (CW - 1);
    return CW'(v);
  endfunction

  function automatic logic signed [SW-1:0] lut(input int g, input logic [GS-1:0] k);
    logic signed [SW-1:0] acc;
    acc = '0;
    for (int j = 0; j < GS; j++)
      if (k[j]) acc = acc + SW'(coef(g * GS + j));
    return acc;
  endfunction

  logic signed [DW-1:0] tap [NTAPS];
  logic [LAT-1:0]       vp;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) tap[i] <= '0;
    end else if (in_valid) begin
      tap[0] <= in_data;
      for (int i = 1; i < NTAPS; i++) tap[i] <= tap[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vp <= '0;
    else     vp <= {vp[LAT-2:0], in_valid};
  end
  assign out_valid = vp[LAT-1];

  logic signed [OW-1:0] term [NP];

  for (genvar b = 0; b < DW; b++) begin : plane
    logic [GS-1:0]        adr [NG];
    logic signed [SW-1:0] hp  [1:2*NG-1];

    always_comb
      for (int g = 0; g < NG; g++)
        for (int j = 0; j < GS; j++)
          adr[g][j] = tap[g*GS+j][b];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 1; i < 2*NG; i++) hp[i] <= '0;
      end else begin
        for (int g = 0; g < NG; g++) hp[NG+g] <= lut(g, adr[g]);
        for (int i = 1; i < NG; i++) hp[i] <= hp[2*i] + hp[2*i+1];
      end
    end

    if (b == DW - 1) begin : neg
      assign term[b] = -(OW'(hp[1]) <<< b);
    end else begin : pos
      assign term[b] = OW'(hp[1]) <<< b;
    end
  end

  for (genvar b = DW; b < NP; b++) begin : pad
    assign term[b] = '0;
  end

  logic signed [OW-1:0] pt [1:NP-1];
  logic signed [OW-1:0] ph [1:2*NP-1];

  always_comb begin
    for (int i = 1; i < NP; i++) ph[i] = pt[i];
    for (int j = 0; j < NP; j++) ph[NP+j] = term[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < NP; i++) pt[i] <= '0;
    end else begin
      for (int i = 1; i < NP; i++) pt[i] <= ph[2*i] + ph[2*i+1];
    end
  end

  assign out_data = pt[1];
endmodule

// File: rtl/da_fir_chk.sv
`timescale 1ns/1ps
module da_fir_chk #(
  parameter int LAT = 10,
  parameter int OW  = 31
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data
);
  logic seen;
  int   since;
  int   idle;

  always_ff @(posedge clk) begin
    seen <= 1'b1;
    if (rst)              since <= 0;
    else if (since < LAT) since <= since + 1;
    if (rst || in_valid)  idle <= 0;
    else if (idle <= LAT) idle <= idle + 1;
  end

  p_reset_clear_r6: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (!out_valid && out_data == '0));

  p_fill_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && since < LAT) |-> !out_valid);

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (since == LAT) |-> (out_valid == $past(in_valid, LAT)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (idle > LAT) |-> ($stable(out_data) && !out_valid));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[OW-1] == out_data[OW-2]));
endmodule

bind da_fir da_fir_chk #(.LAT(LAT), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/da_fir_tb_top.sv
`timescale 1ns/1ps
module da_fir_tb_top;
  localparam int NT   = 64;
  localparam int LATB = 10;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [11:0] in_data = '0;
  logic               out_valid;
  logic signed [30:0] out_data;

  int     cyc = 0;
  int     n_chk = 0;
  int     n_fail = 0;
  longint hist [NT];
  longint exp_q [$];
  int     due_q [$];
  string  tag_q [$];
  longint last_exp = 0;

  da_fir dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint cf(int i);
    return longint'(((i * 173 + 5) % 4096) - 2048);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic send(input logic signed [11:0] x, input string tag);
    longint acc;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(x);
    acc = 0;
    for (int k = 0; k < NT; k++) acc += cf(k) * hist[k];
    exp_q.push_back(acc);
    due_q.push_back(cyc + LATB);
    tag_q.push_back(tag);
    last_exp = acc;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected out_valid", longint'(out_data), 0);
        end else begin
          longint e;
          int     d;
          string  t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          check(longint'(out_data) == e, {t, " value"}, longint'(out_data), e);
          check(d == cyc, {t, " R3 timing"}, longint'(cyc), longint'(d));
        end
      end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
        int d;
        d = due_q.pop_front();
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
        check(1'b0, "R3 R4 missing result", longint'(cyc), longint'(d));
      end
    end
  end

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog expired", longint'(cyc), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (4) @(negedge clk);
    check(!out_valid && out_data == '0, "R6 reset state", longint'(out_data), 0);
    rst = 1'b0;
    idle(3);

    // R1 R2 impulse: outputs walk through the coefficients
    send(12'sd1, "R2 impulse");
    for (int i = 0; i < 70; i++) send(12'sd0, "R1 R2 impulse tail");

    // R4 step, back to back
    for (int i = 0; i < 70; i++) send(12'sd2047, "R1 R4 step");

    // R7 R8 full-scale negative
    for (int i = 0; i < 70; i++) send(-12'sd2048, "R7 R8 full-scale negative");

    // R8 alternating extremes
    for (int i = 0; i < 40; i++) send((i % 2) ? -12'sd2048 : 12'sd2047, "R8 alternating");

    // R5 random samples with gaps
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0]) send(12'(lf[15:4]), "R1 R5 random gaps");
        else       idle(1);
      end
    end

    // R5 hold after drain
    idle(20);
    check(!out_valid && longint'(out_data) == last_exp, "R5 hold after drain",
          longint'(out_data), last_exp);
    idle(5);
    check(!out_valid && longint'(out_data) == last_exp, "R5 still holding",
          longint'(out_data), last_exp);
    check(exp_q.size() == 0, "R3 all results delivered", longint'(exp_q.size()), 0);

    // R6 reset in flight: pending results are dropped, history cleared
    for (int i = 0; i < 5; i++) send(12'sd1000, "R6 before reset");
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    exp_q.delete();
    due_q.delete();
    tag_q.delete();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    check(!out_valid && out_data == '0, "R6 reset mid-run", longint'(out_data), 0);
    rst = 1'b0;
    idle(2);
    check(!out_valid && out_data == '0, "R6 after reset", longint'(out_data), 0);
    send(12'sd5, "R6 cleared history");
    for (int i = 0; i < 20; i++) send(12'sd0, "R6 cleared history tail");
    idle(15);
    check(exp_q.size() == 0, "R3 all results delivered at end", longint'(exp_q.size()), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule